// File: doc/BRIEF.md
# Windowed Prescaled Global Timer

This block is a global timer whose whole register set is reached through two bus offsets. Offset 0x4 holds a register index. Offset 0x0 is a data port, and each access to it lands on the internal register that the stored index names. Software first loads the index and then reads or writes the data port.

Inside the block sit the following:
- a control word holding the master enable and a one-hot divider field;
- a 64-bit free-running counter that steps once per prescaler tick;
- one 64-bit compare value per CPU;
- an interrupt mask with one bit per CPU.

Each CPU's interrupt line is a level. It is high while that CPU's mask bit is set and the counter has reached that CPU's compare value. Masking stops interrupts without stopping time. With a 26 MHz input and divide-by-2 selected, the counter advances at 13 MHz.

Top module: `idx_timer`

## Requirements
- R1: A write to bus offset 0x4 stores the index, and a read of offset 0x4 returns it zero-extended. An access to offset 0x0 targets the register named by the stored index. Read data appears on `bus_rdata` one clock edge after the edge that samples `bus_rd`, and holds until the next read.
- R2: Index 0x00 is the control word. Bit 0 is the enable and bits [10:8] are the divider field. All other bits read as zero, and the word resets to zero.
- R3: The 64-bit counter resets to zero and rises by exactly one on each prescaler tick while the enable is set. While the enable is clear it holds its value.
- R4: Divider value 3'b001 (bit 8 alone) gives one tick per cycle. Value 3'b010 (bit 9 alone) gives one tick every 2 cycles. Value 3'b100 (bit 10 alone) gives one tick every 4 cycles.
- R5: A divider field of zero, or with more than one bit set, behaves as divide-by-1.
- R6: Index 0x08 reads the counter's low 32 bits. Reading it also captures the high 32 bits, and index 0x0C returns that captured value. Writes to either counter index are ignored.
- R7: Index 0x30 is the interrupt mask, one bit per CPU in bits [NCPU-1:0], and it resets to zero.
- R8: CPU n's compare value has its low half at index 0x40+8n and its high half at index 0x44+8n. Both halves reset to all ones.
- R9: `irq[n]` is high exactly when mask bit n is set and the counter is greater than or equal to compare n. Clearing a mask bit drops the line without stopping the counter.
- R10: Reading an unimplemented index returns zero. Writing one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ABITS | Byte offset: 0x0 is the data port, 0x4 is the index port |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | NCPU | Per-CPU interrupt levels |

## Verification
Read data is due one edge after the sampling edge. The bench's scoreboard records the expected word when the strobe is driven, and the monitor pops and compares it at the falling edge that follows.

Counter rates are measured as the difference between two low-half reads whose sampling edges lie exactly eight cycles apart. That difference is 8, 4 or 2 whatever the prescaler phase is. Each measurement waits a few cycles after a control write so that the divider change has settled.

Interrupt lines depend on registered state only. They are checked at a falling edge well after the counter passes the compare value, or after the mask write has been sampled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register indices on the data window (R2, R6, R7, R8)
  localparam int IX_CTRL   = 'h00;
  localparam int IX_CNT_LO = 'h08;
  localparam int IX_CNT_HI = 'h0C;
  localparam int IX_IRQEN  = 'h30;
  localparam int IX_CMP    = 'h40;
  localparam int CMP_STEP  = 8;
  localparam int DIV_LSB   = 8;

  // log2 of the division; anything but a clean one-hot 2 or 4 divides by 1 (R4, R5)
  function automatic logic [1:0] div_log(input logic [2:0] field);
    case (field)
      3'b010:  return 2'd1;
      3'b100:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // Terminal prescale count for a given log2 division
  function automatic logic [2:0] div_limit(input logic [1:0] lg);
    return (3'd1 << lg) - 3'd1;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] lg,
  output logic       tick
);
  import tmr_pkg::*;
  logic [1:0] pcnt_q;
  logic [2:0] lim;

  assign lim  = div_limit(lg);
  // >= so that shrinking the divider never strands the count above the limit
  assign tick = en && ({1'b0, pcnt_q} >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (!en)  pcnt_q <= '0;
    else if (tick) pcnt_q <= '0;
    else           pcnt_q <= pcnt_q + 2'd1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + CW'(1);
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NCPU = 4,
  parameter int CW   = 64
) (
  input  logic [CW-1:0]      count,
  input  logic [NCPU*CW-1:0] cmp,
  input  logic [NCPU-1:0]    mask,
  output logic [NCPU-1:0]    irq
);
  for (genvar n = 0; n < NCPU; n++) begin : g_cpu
    assign irq[n] = mask[n] && (count >= cmp[n*CW +: CW]);
  end
endmodule

// File: rtl/tmr_window.sv
module tmr_window #(
  parameter int NCPU  = 4,
  parameter int DW    = 32,
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               sel_data,
  input  logic               sel_idx,
  input  logic [DW-1:0]      wdata,
  input  logic [2*DW-1:0]    count,
  output logic [DW-1:0]      rdata,
  output logic               ctrl_en,
  output logic [2:0]         div_field,
  output logic [NCPU-1:0]    mask,
  output logic [NCPU*2*DW-1:0] cmp,
  output logic               wr_miss,
  output logic               rd_miss
);
  import tmr_pkg::*;
  localparam int CW = 2 * DW;

  logic [IDX_W-1:0]      idx_q;
  logic [DW-1:0]         shadow_q;
  logic [NCPU-1:0][CW-1:0] cmp_q;
  logic is_ctrl, is_lo, is_hi, is_irqen, known;
  logic [NCPU-1:0] hit_lo, hit_hi;
  logic [DW-1:0] rd_val;

  assign is_ctrl  = idx_q == IDX_W'(IX_CTRL);
  assign is_lo    = idx_q == IDX_W'(IX_CNT_LO);
  assign is_hi    = idx_q == IDX_W'(IX_CNT_HI);
  assign is_irqen = idx_q == IDX_W'(IX_IRQEN);

  for (genvar n = 0; n < NCPU; n++) begin : g_dec
    assign hit_lo[n] = idx_q == IDX_W'(IX_CMP + CMP_STEP * n);
    assign hit_hi[n] = idx_q == IDX_W'(IX_CMP + CMP_STEP * n + 4);
    assign cmp[n*CW +: CW] = cmp_q[n];
  end

  assign known   = is_ctrl || is_lo || is_hi || is_irqen || (|hit_lo) || (|hit_hi);
  assign wr_miss = wr_en && sel_data && !known;
  assign rd_miss = rd_en && sel_data && !known;

  always_comb begin
    rd_val = '0;
    if (is_ctrl) begin
      rd_val[0]                 = ctrl_en;
      rd_val[DIV_LSB +: 3]      = div_field;
    end
    if (is_lo)    rd_val = count[DW-1:0];
    if (is_hi)    rd_val = shadow_q;
    if (is_irqen) rd_val[NCPU-1:0] = mask;
    for (int n = 0; n < NCPU; n++) begin
      if (hit_lo[n]) rd_val = cmp_q[n][DW-1:0];
      if (hit_hi[n]) rd_val = cmp_q[n][CW-1:DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      ctrl_en   <= 1'b0;
      div_field <= '0;
      mask      <= '0;
      shadow_q  <= '0;
      rdata     <= '0;
      for (int n = 0; n < NCPU; n++) cmp_q[n] <= '1;
    end else begin
      if (wr_en && sel_idx) idx_q <= wdata[IDX_W-1:0];
      if (wr_en && sel_data) begin
        if (is_ctrl) begin
          ctrl_en   <= wdata[0];
          div_field <= wdata[DIV_LSB +: 3];
        end
        if (is_irqen) mask <= wdata[NCPU-1:0];
        for (int n = 0; n < NCPU; n++) begin
          if (hit_lo[n]) cmp_q[n][DW-1:0]  <= wdata;
          if (hit_hi[n]) cmp_q[n][CW-1:DW] <= wdata;
        end
      end
      if (rd_en && sel_idx)  rdata <= DW'(idx_q);
      if (rd_en && sel_data) begin
        rdata <= rd_val;
        if (is_lo) shadow_q <= count[CW-1:DW];
      end
    end
  end
endmodule

// File: rtl/idx_timer.sv
module idx_timer #(
  parameter int NCPU  = 4,
  parameter int DW    = 32,
  parameter int IDX_W = 8,
  parameter int ABITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [ABITS-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [NCPU-1:0]  irq
);
  import tmr_pkg::*;
  localparam int CW = 2 * DW;

  logic sel_data, sel_idx, ctrl_en, tick, wr_miss, rd_miss;
  logic [2:0] div_field, div_onehot;
  logic [1:0] lg;
  logic [NCPU-1:0] mask;
  logic [NCPU*CW-1:0] cmp;
  logic [CW-1:0] count;

  assign sel_data   = bus_addr == ABITS'(0);
  assign sel_idx    = bus_addr == ABITS'(4);
  assign lg         = div_log(div_field);
  assign div_onehot = 3'b001 << lg;

  tmr_window #(.NCPU(NCPU), .DW(DW), .IDX_W(IDX_W)) u_win (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
    .sel_data(sel_data), .sel_idx(sel_idx), .wdata(bus_wdata), .count(count),
    .rdata(bus_rdata), .ctrl_en(ctrl_en), .div_field(div_field), .mask(mask),
    .cmp(cmp), .wr_miss(wr_miss), .rd_miss(rd_miss)
  );

  tmr_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .lg(lg), .tick(tick)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count)
  );

  tmr_irq #(.NCPU(NCPU), .CW(CW)) u_irq (
    .count(count), .cmp(cmp), .mask(mask), .irq(irq)
  );
endmodule

// File: rtl/idx_timer_chk.sv
module idx_timer_chk #(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            ctrl_en,
  input logic [2:0]      div_onehot,
  input logic [2*DW-1:0] count,
  input logic [NCPU-1:0] mask,
  input logic [2:0]      div_field,
  input logic            wr_miss,
  input logic            rd_miss,
  input logic [DW-1:0]   rdata
);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> $stable(count));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + 1'b1));
  // R5
  div_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(div_onehot) == 1);
  // R4
  div2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_onehot[1] && $past(div_onehot[1]) && $past(tick)) |-> !tick);
  // R10
  miss_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_miss |=> ($stable(mask) && $stable(div_field) && $stable(ctrl_en)));
  // R10
  miss_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |=> (rdata == '0));
endmodule

bind idx_timer idx_timer_chk #(.NCPU(NCPU), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_en(ctrl_en),
  .div_onehot(div_onehot), .count(count), .mask(mask), .div_field(div_field),
  .wr_miss(wr_miss), .rd_miss(rd_miss), .rdata(bus_rdata)
);

// File: tb/test_idx_timer.sv
module test_idx_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0] irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit chk_q[$];
  logic rd_d = 1'b0;

  always #10 clk = ~clk;

  idx_timer i_idx_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: one result is due the edge after each sampled read strobe
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e = exp_q.pop_front();
      string t = tag_q.pop_front();
      bit c = chk_q.pop_front();
      if (c) check(bus_rdata, e, t);
    end
  end

  task automatic op(input logic [2:0] a, input bit w, input bit r, input logic [31:0] d);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] ix, input logic [31:0] v);
    op(3'd4, 1'b1, 1'b0, {24'd0, ix});
    op(3'd0, 1'b1, 1'b0, v);
  endtask

  task automatic rexp(input logic [7:0] ix, input logic [31:0] e, input string t);
    op(3'd4, 1'b1, 1'b0, {24'd0, ix});
    exp_q.push_back(e); tag_q.push_back(t); chk_q.push_back(1'b1);
    op(3'd0, 1'b0, 1'b1, '0);
  endtask

  task automatic rget(input logic [7:0] ix, output logic [31:0] v);
    op(3'd4, 1'b1, 1'b0, {24'd0, ix});
    exp_q.push_back('0); tag_q.push_back(""); chk_q.push_back(1'b0);
    op(3'd0, 1'b0, 1'b1, '0);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // two low-half samples exactly 8 edges apart
  task automatic rate(input logic [31:0] ctrl, input logic [31:0] exp, input string t);
    logic [31:0] a, b;
    wreg(8'h00, ctrl);
    idle(4);
    rget(8'h08, a);
    idle(6);
    rget(8'h08, b);
    check(b - a, exp, t);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] a, b, lo;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(bus_rdata, 32'h0, "R1 reset rdata");
    check({28'd0, irq}, 32'h0, "R9 reset irq");
    rexp(8'h00, 32'h0, "R2 ctrl reset");
    rexp(8'h30, 32'h0, "R7 mask reset");
    rexp(8'h40, 32'hFFFF_FFFF, "R8 cmp0 low reset");
    rexp(8'h5C, 32'hFFFF_FFFF, "R8 cmp3 high reset");
    rexp(8'h08, 32'h0, "R3 count reset");
    // index port read-back (R1)
    op(3'd4, 1'b1, 1'b0, 32'h0000_00A5);
    exp_q.push_back(32'hA5); tag_q.push_back("R1 index readback"); chk_q.push_back(1'b1);
    op(3'd4, 1'b0, 1'b1, '0);
    // R2 writable bits only
    wreg(8'h00, 32'hFFFF_FFFE);
    rexp(8'h00, 32'h0000_0700, "R2 ctrl mask");
    // rates R4, R5, R3
    rate(32'h101, 32'd8, "R4 div1");
    rate(32'h201, 32'd4, "R4 div2");
    rate(32'h401, 32'd2, "R4 div4");
    rate(32'h001, 32'd8, "R5 empty field");
    rate(32'h301, 32'd8, "R5 two bits");
    rate(32'h700, 32'd0, "R3 disabled holds");
    // R6 counter read-only, shadow high
    rget(8'h08, a);
    wreg(8'h08, 32'h1234_5678);
    wreg(8'h0C, 32'h1234_5678);
    rexp(8'h08, a, "R6 low write ignored");
    rexp(8'h0C, 32'h0, "R6 high shadow");
    // R10 unimplemented index
    wreg(8'h30, 32'h5);
    wreg(8'h20, 32'hFFFF_FFFF);
    rexp(8'h20, 32'h0, "R10 unimpl read");
    rexp(8'h30, 32'h5, "R10 mask untouched");
    rexp(8'h00, 32'h700, "R10 ctrl untouched");
    // R8, R9 compare and mask
    wreg(8'h30, 32'h0);
    rget(8'h08, lo);
    wreg(8'h40, lo + 32'd3);
    wreg(8'h44, 32'h0);
    wreg(8'h48, lo + 32'd120);
    wreg(8'h4C, 32'h0);
    rexp(8'h48, lo + 32'd120, "R8 cmp1 low readback");
    wreg(8'h30, 32'h3);
    idle(1);
    check({28'd0, irq}, 32'h0, "R9 below compare");
    wreg(8'h00, 32'h101);
    idle(10);
    check({28'd0, irq}, 32'h1, "R9 cpu0 reached");
    wreg(8'h30, 32'h2);
    idle(1);
    check({28'd0, irq}, 32'h0, "R9 masked");
    rget(8'h08, a);
    idle(6);
    rget(8'h08, b);
    check(b - a, 32'd8, "R9 counter runs while masked");
    idle(120);
    check({28'd0, irq}, 32'h2, "R9 cpu1 reached");
    idle(2);
    summary();
  end
endmodule